// File: doc/BRIEF.md
# Dual Fractional Baud-Rate Tick Generator

This block turns one reference clock into two independent 16x-oversampling enables, one for a serial transmitter and one for a serial receiver. Each direction has its own two-stage divider. The first stage is a fractional pre-divider. It stretches the reference by a ratio of (16 + S)/16, where S is a 4-bit step value. The second stage is a 16-bit down-counter. It emits one tick every D pre-divider enables. D is assembled from a low-byte and a high-byte register.

Software programs six byte-wide registers through a synchronous write port and can read them back on a combinational read port. A software-reset input clears the whole block in one clock. Each tick is a single-cycle enable in the reference clock domain. A bit period on the line is therefore 16 ticks. A new divisor takes effect only when the running count expires, so a reprogrammed channel never produces a shortened period.

Top module: `dual_baud_gen`

## Requirements
- R1: After the active-low synchronous reset, every register reads back 0 and neither tick output pulses.
- R2: Address bit 2 selects the channel (0 transmit, 1 receive). Address bits 1:0 select the register: 0 is the divisor bits 7:0, 1 is the divisor bits 15:8, 2 is the step. Writes with bits 1:0 equal to 3 change nothing, and reads there return 0.
- R3: The step register keeps only the 4 least significant bits written; bits 7:4 always read as 0.
- R4: A channel whose divisor is 0 produces no ticks once its current count has expired.
- R5: With step 0, ticks on a channel are exactly D clocks apart, D = 256*high + low.
- R6: Any window of D*(16+S) consecutive clocks holds exactly 16 ticks of that channel.
- R7: Consecutive ticks are floor(D*(16+S)/16) or ceil(D*(16+S)/16) clocks apart.
- R8: The two channels run at their own programmed rates at the same time, with no influence on each other.
- R9: A divisor write is taken up only when the running count expires. The period in progress keeps the old value, and this holds also when the write lands in the same clock as the expiry.
- R10: The software reset is synchronous. One clock after it is sampled, all registers are 0 and no tick is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (bit 2 channel, bits 1:0 register) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| tx_tick | output | 1 | Transmit 16x enable, one clock wide |
| rx_tick | output | 1 | Receive 16x enable, one clock wide |

## Verification
The collision that matters here is a divisor write landing in the very clock in which the down-counter expires and reloads. The bench runs one channel with step 0, where the tick position is fully predictable. It counts clocks from an observed tick and times the write strobe so that the write is sampled on the same edge that raises the next tick. The result is judged by the next two tick intervals: the first must still equal the old divisor and only the second the new one. A write a few clocks into the period is checked the same way.

// File: rtl/baud_gen_pkg.sv
// Shared constants and the register-select encoding of the baud generator.
package baud_gen_pkg;

    // Number of independent rate channels (transmit, receive).
    localparam int NCH   = 2;
    localparam int CH_TX = 0;
    localparam int CH_RX = 1;

    // Register select carried in address bits 1:0.
    typedef enum logic [1:0] {
        SEL_DIV_LO = 2'd0,
        SEL_DIV_HI = 2'd1,
        SEL_STEP   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/baud_cfg_regs.sv
// Configuration register file for the two rate channels.
// Holds one divisor (two bytes) and one fractional step per channel.
// Assumes: the channel is picked by the top address bit and the register by
// bits 1:0. Both resets clear every field. Reads are combinational.
module baud_cfg_regs
    import baud_gen_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sw_rst,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    output logic [NCH-1:0][2*DATA_W-1:0]    div_o,
    output logic [NCH-1:0][PRE_W-1:0]       step_o
);

    localparam int DIV_W  = 2 * DATA_W;
    localparam int CH_BIT = ADDR_W - 1;

    reg_sel_e wr_sel;
    reg_sel_e rd_sel;
    logic     rd_ch;

    assign wr_sel = reg_sel_e'(wr_addr[1:0]);
    assign rd_sel = reg_sel_e'(rd_addr[1:0]);
    assign rd_ch  = rd_addr[CH_BIT];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [DIV_W-1:0] div_q;
        logic [PRE_W-1:0] step_q;
        logic             hit;

        assign hit = wr_en && (wr_addr[CH_BIT] == 1'(ch));

        // Capture byte writes addressed to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n || sw_rst) begin
                div_q  <= '0;
                step_q <= '0;
            end else if (hit) begin
                case (wr_sel)
                    SEL_DIV_LO: div_q[DATA_W-1:0]     <= wr_data;
                    SEL_DIV_HI: div_q[DIV_W-1:DATA_W] <= wr_data;
                    SEL_STEP:   step_q                <= wr_data[PRE_W-1:0];
                    default:    ;
                endcase
            end
        end

        assign div_o[ch]  = div_q;
        assign step_o[ch] = step_q;
    end

    // Read-back multiplexer; the upper step bits and unmapped slots read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_DIV_LO: rd_data = div_o[rd_ch][DATA_W-1:0];
            SEL_DIV_HI: rd_data = div_o[rd_ch][DIV_W-1:DATA_W];
            SEL_STEP:   rd_data = DATA_W'(step_o[rd_ch]);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/frac_prescaler.sv
// Fractional pre-divider: emits 2**PRE_W enables in every (2**PRE_W + step)
// clocks, spread as evenly as possible (ratio 1 + step/2**PRE_W).
// Assumes: step may change at any time. The phase accumulator stays bounded
// and settles into the new pattern within a few enables.
module frac_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic [PRE_W-1:0] step_i,
    output logic             en_o
);

    localparam int                ACC_W = PRE_W + 2;
    localparam logic [ACC_W-1:0]  UNIT  = ACC_W'(1) << PRE_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] modulus;
    logic             wrap;

    // Add one unit per clock and wrap on the modulus 2**PRE_W + step.
    always_comb begin
        sum     = acc_q + UNIT;
        modulus = UNIT + ACC_W'(step_i);
        wrap    = (sum >= modulus);
    end

    // Keep the remainder and register the enable.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            acc_q <= '0;
            en_o  <= 1'b0;
        end else begin
            acc_q <= wrap ? (sum - modulus) : sum;
            en_o  <= wrap;
        end
    end

endmodule

// File: rtl/divisor_counter.sv
// Integer divider stage: one tick for every div_i prescaler enables.
// Assumes: the divisor is read only when the count expires, so a change never
// shortens the period in progress. A zero divisor parks the counter idle.
module divisor_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             step_en,
    input  logic [CNT_W-1:0] div_i,
    output logic             tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             armed;

    assign expire = step_en && (cnt_q == '0);
    assign armed  = (div_i != '0);

    // Count enables down; reload from the live divisor only at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= expire && armed;
            if (expire) begin
                cnt_q <= armed ? (div_i - CNT_W'(1)) : '0;
            end else if (step_en) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dual_baud_gen.sv
// Top of the dual baud tick generator: the register file feeds one
// prescaler and divider pair for each direction.
// Assumes: a single reference clock domain; the ticks are clock enables.
module dual_baud_gen
    import baud_gen_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_tick,
    output logic              rx_tick
);

    localparam int DIV_W = 2 * DATA_W;

    logic [NCH-1:0][DIV_W-1:0] div_cfg;
    logic [NCH-1:0][PRE_W-1:0] step_cfg;
    logic [NCH-1:0]            pre_en;
    logic [NCH-1:0]            tick;

    baud_cfg_regs #(
        .DATA_W (DATA_W),
        .PRE_W  (PRE_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .div_o   (div_cfg),
        .step_o  (step_cfg)
    );

    // One independent rate chain per direction.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        frac_prescaler #(
            .PRE_W (PRE_W)
        ) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_rst (sw_rst),
            .step_i (step_cfg[ch]),
            .en_o   (pre_en[ch])
        );

        divisor_counter #(
            .CNT_W (DIV_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_rst  (sw_rst),
            .step_en (pre_en[ch]),
            .div_i   (div_cfg[ch]),
            .tick_o  (tick[ch])
        );
    end

    assign tx_tick = tick[CH_TX];
    assign rx_tick = tick[CH_RX];

endmodule

// File: rtl/dual_baud_gen_chk.sv
// Property checker for dual_baud_gen, attached to every instance by bind.
// Assumes: it observes the ports and the internal configuration and enable nets.
module dual_baud_gen_chk
    import baud_gen_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sw_rst,
    input  logic [1:0]                    rd_sel,
    input  logic [DATA_W-1:0]             rd_data,
    input  logic                          tx_tick,
    input  logic                          rx_tick,
    input  logic [NCH-1:0][2*DATA_W-1:0]  div_cfg,
    input  logic [NCH-1:0][PRE_W-1:0]     step_cfg,
    input  logic [NCH-1:0]                pre_en
);

    // R3
    step_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2) |-> (rd_data[DATA_W-1:PRE_W] == '0));

    // R2
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> (rd_data == '0));

    // R4
    tx_tick_needs_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> ($past(div_cfg[CH_TX]) != '0));

    // R4
    rx_tick_needs_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> ($past(div_cfg[CH_RX]) != '0));

    // R6
    tx_tick_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> $past(pre_en[CH_TX]));

    // R6
    rx_tick_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> $past(pre_en[CH_RX]));

    // R5
    tx_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(step_cfg[CH_TX]) == '0) && $past(rst_n) && !$past(sw_rst)) |-> pre_en[CH_TX]);

    // R5
    rx_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(step_cfg[CH_RX]) == '0) && $past(rst_n) && !$past(sw_rst)) |-> pre_en[CH_RX]);

    // R10
    sw_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_rst) |-> (!tx_tick && !rx_tick && (div_cfg == '0) && (step_cfg == '0)));

endmodule

bind dual_baud_gen dual_baud_gen_chk #(
    .DATA_W (DATA_W),
    .PRE_W  (PRE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .rd_sel   (rd_addr[1:0]),
    .rd_data  (rd_data),
    .tx_tick  (tx_tick),
    .rx_tick  (rx_tick),
    .div_cfg  (div_cfg),
    .step_cfg (step_cfg),
    .pre_en   (pre_en)
);

// File: tb/tb_dual_baud_gen.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every step value against several divisors on
// both channels, then probes reset, zero divisor and divisor-change timing.
module tb_dual_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tx_tick;
    logic       rx_tick;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_baud_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .tx_tick (tx_tick),
        .rx_tick (rx_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic tick_of(input int ch);
        return (ch != 0) ? rx_tick : tx_tick;
    endfunction

    // Called at a falling edge; the write is sampled on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic cfg(input int ch, input int step, input int div);
        logic [2:0] base;
        base = (ch != 0) ? 3'd4 : 3'd0;
        wr(base + 3'd0, div[7:0]);
        wr(base + 3'd1, div[15:8]);
        wr(base + 3'd2, step[7:0]);
    endtask

    task automatic wait_tick(input int ch);
        do @(negedge clk); while (!tick_of(ch));
    endtask

    task automatic count_ticks(input int ch, input int len, output int n);
        n = 0;
        repeat (len) begin
            @(negedge clk);
            if (tick_of(ch)) n++;
        end
    endtask

    // Window count plus interval bounds for one channel.
    task automatic check_rate(input int ch, input int step, input int div,
                              input string wtag, input string itag);
        int span;
        int lo;
        int hi;
        int n;
        int last;
        int iv;
        span = div * (16 + step);
        lo   = span / 16;
        hi   = (span + 15) / 16;
        count_ticks(ch, span, n);
        chk(n == 16, $sformatf("%s ticks in window ch%0d s%0d d%0d", wtag, ch, step, div), n, 16);
        wait_tick(ch);
        last = cyc;
        for (int i = 0; i < 3; i++) begin
            wait_tick(ch);
            iv = cyc - last;
            last = cyc;
            chk(iv >= lo && iv <= hi,
                $sformatf("%s interval ch%0d s%0d d%0d (max %0d)", itag, ch, step, div, hi), iv, lo);
        end
    endtask

    task automatic period_exact(input int ch, input int div, input string tag);
        int last;
        wait_tick(ch);
        last = cyc;
        for (int i = 0; i < 2; i++) begin
            wait_tick(ch);
            chk(cyc - last == div, $sformatf("%s exact period ch%0d", tag, ch), cyc - last, div);
            last = cyc;
        end
    endtask

    initial begin
        int v;
        int n;
        int n2;
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R1 reset readback", v, 0);
        end
        fork
            count_ticks(0, 50, n);
            count_ticks(1, 50, n2);
        join
        chk(n == 0, "R1 no tx tick after reset", n, 0);
        chk(n2 == 0, "R1 no rx tick after reset", n2, 0);

        // R2 / R3: address map, truncated step, unmapped slots
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'hA5);
        wr(3'd4, 8'h33); wr(3'd5, 8'h44); wr(3'd6, 8'h5C);
        wr(3'd3, 8'hFF); wr(3'd7, 8'hEE);
        rd(3'd0, v); chk(v == 8'h11, "R2 tx low byte", v, 8'h11);
        rd(3'd1, v); chk(v == 8'h22, "R2 tx high byte", v, 8'h22);
        rd(3'd2, v); chk(v == 8'h05, "R3 tx step upper bits zero", v, 8'h05);
        rd(3'd4, v); chk(v == 8'h33, "R2 rx low byte", v, 8'h33);
        rd(3'd5, v); chk(v == 8'h44, "R2 rx high byte", v, 8'h44);
        rd(3'd6, v); chk(v == 8'h0C, "R3 rx step upper bits zero", v, 8'h0C);
        rd(3'd3, v); chk(v == 0, "R2 unmapped tx slot", v, 0);
        rd(3'd7, v); chk(v == 0, "R2 unmapped rx slot", v, 0);

        // R6 / R7 / R8: every step value against three divisors, both channels at once
        for (int s = 0; s < 16; s++) begin
            for (int di = 0; di < 3; di++) begin
                int d;
                d = (di == 0) ? 1 : ((di == 1) ? 3 : 7);
                cfg(0, s, d);
                cfg(1, 15 - s, d + 1);
                repeat (100) @(negedge clk);
                fork
                    check_rate(0, s, d, "R6", "R7");
                    check_rate(1, 15 - s, d + 1, "R8", "R8");
                join
            end
        end

        // R5: exact periods, one using the high byte
        cfg(0, 0, 256);
        cfg(1, 0, 16);
        repeat (300) @(negedge clk);
        fork
            period_exact(0, 256, "R5");
            period_exact(1, 16, "R5");
        join

        // R4: zero divisor silences the channel
        cfg(0, 0, 0);
        cfg(1, 5, 0);
        repeat (300) @(negedge clk);
        fork
            count_ticks(0, 200, n);
            count_ticks(1, 200, n2);
        join
        chk(n == 0, "R4 tx silent with zero divisor", n, 0);
        chk(n2 == 0, "R4 rx silent with zero divisor", n2, 0);

        // R9: write a few clocks into the period
        cfg(0, 0, 6);
        repeat (20) @(negedge clk);
        wait_tick(0);
        c0 = cyc;
        repeat (2) @(negedge clk);
        wr(3'd0, 8'd3);
        wait_tick(0);
        chk(cyc - c0 == 6, "R9 period in progress keeps old divisor", cyc - c0, 6);
        c0 = cyc;
        wait_tick(0);
        chk(cyc - c0 == 3, "R9 new divisor after expiry", cyc - c0, 3);

        // R9: write sampled on the same edge as the expiry
        wr(3'd0, 8'd5);
        repeat (20) @(negedge clk);
        wait_tick(0);
        c0 = cyc;
        repeat (4) @(negedge clk);
        wr(3'd0, 8'd2);
        chk(tx_tick == 1'b1 && cyc - c0 == 5, "R9 tick on collision edge", cyc - c0, 5);
        c0 = cyc;
        wait_tick(0);
        chk(cyc - c0 == 5, "R9 collision reload uses old divisor", cyc - c0, 5);
        c0 = cyc;
        wait_tick(0);
        chk(cyc - c0 == 2, "R9 collision new divisor next period", cyc - c0, 2);

        // R10: software reset
        cfg(0, 3, 5);
        cfg(1, 0, 2);
        repeat (50) @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        chk(tx_tick == 1'b0, "R10 tx tick cleared", int'(tx_tick), 0);
        chk(rx_tick == 1'b0, "R10 rx tick cleared", int'(rx_tick), 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R10 registers cleared", v, 0);
        end
        fork
            count_ticks(0, 60, n);
            count_ticks(1, 60, n2);
        join
        chk(n + n2 == 0, "R10 no ticks after software reset", n + n2, 0);
        cfg(0, 0, 4);
        repeat (20) @(negedge clk);
        period_exact(0, 4, "R10");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected below %0d", cyc, 200000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule